// File: doc/BRIEF.md
# Lockable 64-bit Monotonic Counter

This block keeps a 64-bit count that software sees as two separate 32-bit registers, a low half and a high half. A mode bit in a control register decides what a write to the counter does. In counting mode, a write to the low half advances the full 64-bit value by exactly one, and the written data is thrown away. In load mode, a write to either half replaces that half with the data.

Carrying past the top of the high half raises a sticky overflow flag. While the flag is up, both halves read as zero and further count requests do nothing. The only way to clear the flag is a write to the high half in load mode. An interrupt-enable bit routes the flag to a registered interrupt output.

Three one-way lock bits guard the low half, the high half and the control register. Software can clear a lock bit, but only the lock reset input (`soft_rst`) sets it again. A count request made while the time-invalid input is high is dropped.

A read of the low half also copies the high half into a shadow register, and a later read of the high half returns that copy. Software therefore reads low then high and always gets one coherent 64-bit value.

Top module: `mono_counter`

## Requirements
- R1: After `rst`, the control register, both halves, the overflow flag, `bus_rdata` and `ovf_irq` are 0, and all three lock bits are 1.
- R2: Register map: 0 is control (bit0 counting mode, bit1 interrupt enable), 1 is the low half, 2 is the high half, 3 is locks (bit0 low, bit1 high, bit2 control), 4 is status (bit0 overflow flag). Other addresses read 0 and ignore writes.
- R3: In counting mode, an accepted write to address 1 adds one to the 64-bit value {high, low}, whatever the data. A carry out of the low half increments the high half.
- R4: In load mode, an accepted write to address 1 or 2 loads that half with `bus_wdata`.
- R5: In counting mode, a write to address 1 while `time_invalid` is 1 leaves the counter unchanged.
- R6: An increment from all ones sets the sticky overflow flag. While the flag is set, increments have no effect and reads of both halves return 0.
- R7: A write to address 2 in load mode clears the overflow flag. A write to address 2 in counting mode is ignored.
- R8: Writing address 3 clears each lock bit written as 0; bits written as 1 are unchanged. A write to a register whose lock bit is 0 is ignored.
- R9: A `soft_rst` pulse sets all lock bits to 1 and leaves the counter, the flag and the control register unchanged.
- R10: `ovf_irq` equals (overflow flag AND interrupt enable) as they stood one cycle earlier.
- R11: Reading address 1 captures the visible high half into a shadow. A later read of address 2 returns that shadow, even if the high half changed in between.
- R12: `bus_rdata` updates in the cycle after `bus_rd`. A read in the same cycle as a write returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| soft_rst | input | 1 | Synchronous reset of the lock bits only |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| time_invalid | input | 1 | When high, count requests are dropped |
| ovf_irq | output | 1 | Registered overflow interrupt |

## Verification
A read of the low half can land in the same cycle as an increment or a load of the counter. The read must return the value from before the write, and the shadow must capture the old high half. The bench provokes this in directed steps and in random operations that assert read and write strobes together. It judges the result against a model that evaluates the read from its pre-write state before applying the write. Overflow is driven directly by loading all ones and counting once, with the interrupt enabled.

// File: rtl/mono_counter_pkg.sv
package mono_counter_pkg;
  localparam int ADDR_W = 3;
  localparam int LOCK_N = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOCK = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int LK_LO   = 0;
  localparam int LK_HI   = 1;
  localparam int LK_CTRL = 2;
endpackage

// File: rtl/mono_counter_lock.sv
module mono_counter_lock #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] open_o
);
  // One flop per lock: cleared by a 0 write, reopened only by reset.
  for (genvar i = 0; i < N; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst || soft_rst)
        open_o[i] <= 1'b1;
      else if (clr_we && !clr_data[i])
        open_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mono_counter_core.sv
module mono_counter_core #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              ovf
);
  localparam int SUM_W = HALF_W + 1;

  logic [SUM_W-1:0] lo_sum;
  logic [SUM_W-1:0] hi_sum;
  logic             lo_carry;
  logic             hi_carry;

  always_comb begin
    lo_sum   = {1'b0, cnt_lo} + SUM_W'(1);
    hi_sum   = {1'b0, cnt_hi} + SUM_W'(1);
    lo_carry = lo_sum[HALF_W];
    hi_carry = hi_sum[HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      ovf    <= 1'b0;
    end else begin
      if (inc && !ovf) begin
        cnt_lo <= lo_sum[HALF_W-1:0];
        if (lo_carry) begin
          cnt_hi <= hi_sum[HALF_W-1:0];
          if (hi_carry)
            ovf <= 1'b1;
        end
      end
      if (ld_lo)
        cnt_lo <= wdata;
      if (ld_hi) begin
        cnt_hi <= wdata;
        ovf    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mono_counter_readback.sv
module mono_counter_readback
  import mono_counter_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic [HALF_W-1:0] cnt_hi,
  input  logic              ovf,
  input  logic              mode,
  input  logic              irq_en,
  input  logic [LOCK_N-1:0] locks,
  output logic [HALF_W-1:0] rdata
);
  logic [HALF_W-1:0] shadow_hi;
  logic [HALF_W-1:0] vis_lo;
  logic [HALF_W-1:0] vis_hi;

  always_comb begin
    vis_lo = ovf ? '0 : cnt_lo;
    vis_hi = ovf ? '0 : cnt_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      shadow_hi <= '0;
    end else if (rd) begin
      case (addr)
        A_CTRL: rdata <= HALF_W'({irq_en, mode});
        A_LO: begin
          rdata     <= vis_lo;
          shadow_hi <= vis_hi;
        end
        A_HI:   rdata <= shadow_hi;
        A_LOCK: rdata <= HALF_W'(locks);
        A_STAT: rdata <= HALF_W'(ovf);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mono_counter.sv
module mono_counter
  import mono_counter_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  input  logic              time_invalid,
  output logic              ovf_irq
);
  logic              mode_q;
  logic              irq_en_q;
  logic [LOCK_N-1:0] lock_open;
  logic [HALF_W-1:0] cnt_lo;
  logic [HALF_W-1:0] cnt_hi;
  logic              ovf_flag;
  logic              wr_ctrl, wr_lock, do_inc, do_ld_lo, do_ld_hi;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL) && lock_open[LK_CTRL];
    wr_lock  = bus_wr && (bus_addr == A_LOCK);
    do_inc   = bus_wr && (bus_addr == A_LO) && lock_open[LK_LO] && mode_q && !time_invalid;
    do_ld_lo = bus_wr && (bus_addr == A_LO) && lock_open[LK_LO] && !mode_q;
    do_ld_hi = bus_wr && (bus_addr == A_HI) && lock_open[LK_HI] && !mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      irq_en_q <= 1'b0;
      ovf_irq  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q   <= bus_wdata[0];
        irq_en_q <= bus_wdata[1];
      end
      ovf_irq <= ovf_flag && irq_en_q;
    end
  end

  mono_counter_lock #(.N(LOCK_N)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .clr_we   (wr_lock),
    .clr_data (bus_wdata[LOCK_N-1:0]),
    .open_o   (lock_open)
  );

  mono_counter_core #(.HALF_W(HALF_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .inc    (do_inc),
    .ld_lo  (do_ld_lo),
    .ld_hi  (do_ld_hi),
    .wdata  (bus_wdata),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .ovf    (ovf_flag)
  );

  mono_counter_readback #(.HALF_W(HALF_W)) u_rb (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .ovf    (ovf_flag),
    .mode   (mode_q),
    .irq_en (irq_en_q),
    .locks  (lock_open),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/mono_counter_chk.sv
module mono_counter_chk
  import mono_counter_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [HALF_W-1:0] bus_rdata,
  input logic              time_invalid,
  input logic              ovf_irq,
  input logic              mode,
  input logic [LOCK_N-1:0] locks,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic              ovf
);
  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_LO && mode && !time_invalid && locks[LK_LO] && !ovf
    |=> {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1);

  // R5
  tinv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_LO && mode && time_invalid
    |=> $stable({cnt_hi, cnt_lo}));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf && !(bus_wr && bus_addr == A_HI) |=> ovf);

  // R6
  ovf_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf && bus_rd && bus_addr == A_LO |=> bus_rdata == '0);

  // R6
  ovf_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(bus_wr && bus_addr == A_LO && mode));

  // R8
  lock_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_HI && !locks[LK_HI] |=> $stable(cnt_hi));

  // R9
  lock_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    (|(locks & ~$past(locks))) |-> ($past(soft_rst) || $past(rst)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> $past(ovf));
endmodule

bind mono_counter mono_counter_chk #(.HALF_W(HALF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .soft_rst     (soft_rst),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .time_invalid (time_invalid),
  .ovf_irq      (ovf_irq),
  .mode         (mode_q),
  .locks        (lock_open),
  .cnt_lo       (cnt_lo),
  .cnt_hi       (cnt_hi),
  .ovf          (ovf_flag)
);

// File: tb/test_mono_counter.sv
module test_mono_counter;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic [2:0]    addr = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [HW-1:0] wdata = '0;
  logic          tinv = 1'b0;
  logic [HW-1:0] rdata;
  logic          irq;

  logic [HW-1:0] m_lo, m_hi, m_shadow;
  logic          m_mode, m_ie, m_ovf, m_irq;
  logic [2:0]    m_lock;
  int            n_vec = 0;
  int            n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_counter #(.HALF_W(HW)) i_mono_counter (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_addr(addr),
    .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
    .time_invalid(tinv), .ovf_irq(irq)
  );

  function automatic logic [2*HW-1:0] inc64(logic [HW-1:0] hi, logic [HW-1:0] lo);
    return {hi, lo} + 1'b1;
  endfunction

  function automatic logic [HW-1:0] read_val(logic [2:0] a);
    case (a)
      3'd0: return HW'({m_ie, m_mode});
      3'd1: return m_ovf ? '0 : m_lo;
      3'd2: return m_shadow;
      3'd3: return HW'(m_lock);
      3'd4: return HW'(m_ovf);
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [HW-1:0] act, logic [HW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [2:0] a, logic [HW-1:0] d, bit ti);
    case (a)
      3'd0: if (m_lock[2]) begin m_mode = d[0]; m_ie = d[1]; end
      3'd1: if (m_lock[0]) begin
        if (m_mode) begin
          if (!ti && !m_ovf) begin
            {m_hi, m_lo} = inc64(m_hi, m_lo);
            if ({m_hi, m_lo} == '0) m_ovf = 1'b1;
          end
        end else m_lo = d;
      end
      3'd2: if (m_lock[1] && !m_mode) begin m_hi = d; m_ovf = 1'b0; end
      3'd3: m_lock = m_lock & d[2:0];
      default: ;
    endcase
  endtask

  task automatic op(bit w, bit r, logic [2:0] a, logic [HW-1:0] d, bit ti, string req);
    logic [HW-1:0] exp_rd;
    logic          nxt_irq;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; tinv = ti;
    exp_rd  = read_val(a);
    nxt_irq = m_ovf & m_ie;
    if (r && a == 3'd1) m_shadow = m_ovf ? '0 : m_hi;
    if (w) model_write(a, d, ti);
    m_irq = nxt_irq;
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0; tinv = 1'b0;
    if (r) check(req, rdata, exp_rd);
    check("R10 irq", HW'(irq), HW'(m_irq));
  endtask

  task automatic wr_op(logic [2:0] a, logic [HW-1:0] d, string req);
    op(1'b1, 1'b0, a, d, 1'b0, req);
  endtask

  task automatic rd_op(logic [2:0] a, string req);
    op(1'b0, 1'b1, a, '0, 1'b0, req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_lo = '0; m_hi = '0; m_shadow = '0; m_mode = 1'b0; m_ie = 1'b0;
    m_ovf = 1'b0; m_irq = 1'b0; m_lock = 3'b111;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 rdata", rdata, '0);
    check("R1 irq", HW'(irq), '0);
    for (int a = 0; a < 6; a++) rd_op(3'(a), "R1 reset read");

    // R4 load mode
    wr_op(3'd1, 32'h11, "R4");
    wr_op(3'd2, 32'h22, "R4");
    rd_op(3'd1, "R4 lo"); rd_op(3'd2, "R4 hi");
    // R3 counting mode ignores data
    wr_op(3'd0, 32'h1, "R2 ctrl");
    wr_op(3'd1, 32'hdead_beef, "R3");
    rd_op(3'd0, "R2 ctrl"); rd_op(3'd1, "R3 lo"); rd_op(3'd2, "R3 hi");
    // R5 time invalid
    op(1'b1, 1'b0, 3'd1, 32'h0, 1'b1, "R5");
    rd_op(3'd1, "R5 lo");
    // R3 carry into high half
    wr_op(3'd0, 32'h0, "R2");
    wr_op(3'd1, 32'hffff_ffff, "R4");
    wr_op(3'd2, 32'h7, "R4");
    wr_op(3'd0, 32'h1, "R2");
    wr_op(3'd1, 32'h0, "R3");
    rd_op(3'd1, "R3 carry lo"); rd_op(3'd2, "R3 carry hi");
    // R11 coherent snapshot
    rd_op(3'd1, "R11 lo");
    wr_op(3'd0, 32'h0, "R2");
    wr_op(3'd2, 32'h99, "R4");
    rd_op(3'd2, "R11 stale shadow");
    rd_op(3'd1, "R11 lo"); rd_op(3'd2, "R11 new hi");
    // R7 high write ignored in counting mode
    wr_op(3'd0, 32'h1, "R2");
    wr_op(3'd2, 32'h55, "R7");
    rd_op(3'd1, "R7 lo"); rd_op(3'd2, "R7 hi");
    // R6 overflow with interrupt enabled
    wr_op(3'd0, 32'h0, "R2");
    wr_op(3'd1, 32'hffff_ffff, "R4");
    wr_op(3'd2, 32'hffff_ffff, "R4");
    wr_op(3'd0, 32'h3, "R2");
    wr_op(3'd1, 32'h0, "R6");
    rd_op(3'd4, "R6 flag");
    rd_op(3'd1, "R6 lo zero"); rd_op(3'd2, "R6 hi zero");
    wr_op(3'd1, 32'h0, "R6 frozen");
    rd_op(3'd1, "R6 frozen lo");
    rd_op(3'd4, "R10 flag held");
    // R7 clear in load mode
    wr_op(3'd0, 32'h2, "R2");
    wr_op(3'd2, 32'h4, "R7");
    rd_op(3'd4, "R7 cleared");
    rd_op(3'd1, "R7 lo"); rd_op(3'd2, "R7 hi");
    // R12 read and increment in one cycle
    wr_op(3'd0, 32'h1, "R2");
    op(1'b1, 1'b1, 3'd1, 32'h0, 1'b0, "R12 read before inc");
    rd_op(3'd1, "R12 after");
    // R8 locks
    wr_op(3'd0, 32'h0, "R2");
    wr_op(3'd3, 32'h6, "R8");
    wr_op(3'd1, 32'h1234, "R8 lo locked");
    rd_op(3'd1, "R8 lo");
    wr_op(3'd3, 32'h7, "R8 ones");
    rd_op(3'd3, "R8 lock bits");
    wr_op(3'd3, 32'h3, "R8");
    wr_op(3'd0, 32'h3, "R8 ctrl locked");
    rd_op(3'd0, "R8 ctrl");
    wr_op(3'd2, 32'h77, "R8 hi open");
    rd_op(3'd1, "R8"); rd_op(3'd2, "R8 hi");
    // R9 soft reset reopens locks only
    @(negedge clk); soft_rst = 1'b1;
    m_irq = m_ovf & m_ie;
    @(posedge clk); #1; soft_rst = 1'b0; m_lock = 3'b111;
    rd_op(3'd3, "R9 locks");
    rd_op(3'd0, "R9 ctrl"); rd_op(3'd1, "R9 lo"); rd_op(3'd2, "R9 hi");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]    a;
      logic [HW-1:0] d;
      bit            w, r, ti;
      a  = 3'($urandom_range(0, 5));
      w  = ($urandom % 2) == 0;
      r  = ($urandom % 2) == 0;
      ti = ($urandom % 4) == 0;
      if (a == 3'd3) w = 1'b0;
      case ($urandom % 4)
        0: d = 32'hffff_ffff;
        1: d = 32'hffff_fffe;
        default: d = $urandom;
      endcase
      op(w, r, a, d, ti, "R12 random");
    end
    summary();
    $finish;
  end
endmodule